// File: doc/BRIEF.md
# Single-Wire Bus Slave Reset and Presence Responder

This block is the reset-detection front end of a slave on a single-wire, open-drain bus, clocked by a fixed system clock. It passes the raw line through a two-flop synchronizer and measures the length of every low period. When the line returns high, it classifies that low period as a bus reset or as an ordinary slot low, using the overdrive state from the command layer to choose the thresholds.

After a reset it waits a short high time and then enables its open-drain pulldown for the presence pulse. Timing comes from the standard or overdrive parameter set, whichever speed the reset leaves the device in. A one-cycle strobe at the end of the recovery window tells the command layer that the bus is ready for data. A separate flag, issued with the reset strobe, tells the command layer to return to standard speed. All durations are parameters in system clocks. Data-bit slots and command decoding are handled elsewhere.

Top module: `owire_reset_responder`

## Requirements
- R1: A low period of at least `LONG_CLKS` clocks raises `resetPulse` and `speedDrop` together at either speed.
- R2: At standard speed (`odMode` = 0), a low period shorter than `LONG_CLKS` raises `slotEnd` only. There is no `resetPulse` and no pulldown.
- R3: In overdrive (`odMode` = 1), a low period from `OD_MIN_CLKS` to `OD_MAX_CLKS` inclusive raises `resetPulse` with `speedDrop` = 0, and the presence pulse then uses the overdrive timing.
- R4: In overdrive, a low period longer than `OD_MAX_CLKS` and shorter than `LONG_CLKS` is a reset with `speedDrop` = 1, and the presence pulse then uses the standard timing.
- R5: In overdrive, a low period shorter than `OD_MIN_CLKS` raises `slotEnd` only.
- R6: `pullDown` rises exactly PDH clocks after the cycle in which `resetPulse` is high, and stays high for exactly PDL clocks. PDH and PDL are taken from the set for the speed kept after the reset.
- R7: `readyPulse` is high for one cycle exactly RSTH clocks after `resetPulse`, using the RSTH of the speed kept after the reset. RSTH must be at least PDH + PDL + `REC_CLKS`.
- R8: A low period that starts during the presence sequence, before `readyPulse`, is never classified. When it ends there is no `resetPulse` and no `slotEnd`.
- R9: After `rstN` is released, all outputs stay low while the bus is idle high. `pullDown` is never high outside the presence window.
- R10: `resetPulse`, `slotEnd` and `readyPulse` are single-cycle and mutually exclusive. A classification strobe appears at the third clock edge after the first edge that samples the line high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busIn | input | 1 | Raw bus line level (1 = released) |
| odMode | input | 1 | Current overdrive state from the command layer |
| pullDown | output | 1 | Open-drain pulldown enable for the presence pulse |
| resetPulse | output | 1 | One-cycle strobe: a bus reset was detected |
| speedDrop | output | 1 | With resetPulse: return to standard speed |
| slotEnd | output | 1 | One-cycle strobe: a non-reset low period ended |
| readyPulse | output | 1 | One-cycle strobe: recovery window over, ready for data |

## Verification
Low periods are driven at each threshold and one clock either side of it, at both speeds: lengths just under and at the long-reset limit, and at and around the overdrive minimum and maximum. Each of these tells apart two outcomes among slot, reset that keeps speed, and reset that drops speed. Random lengths from one clock to beyond the long limit, at random speeds, cover the space in between. After every reset, the presence start, presence width and ready time are measured, which shows whether the latched speed chose the right timing set. A master low that starts inside the presence pulse and outlasts the ready strobe checks that such a low is ignored and that a later genuine reset still works.

// File: rtl/owrp_pkg.sv
package owrp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_PRES,
    ST_REC
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startSeq;  // reset classified: clear timer, latch speed
    logic keepOd;    // speed kept after this reset is overdrive
    logic seqRun;    // presence/recovery sequence in progress
    logic measEn;    // low-period measurement allowed
  } ctlStrobe_t;

endpackage

// File: rtl/owrp_datapath.sv
module owrp_datapath
  import owrp_pkg::*;
#(
  parameter int LONG_CLKS = 24000,
  parameter int PDH_STD   = 1500,
  parameter int PDL_STD   = 6000,
  parameter int RSTH_STD  = 24000,
  parameter int PDH_OD    = 150,
  parameter int PDL_OD    = 600,
  parameter int RSTH_OD   = 2400,
  localparam int LW = $clog2(LONG_CLKS + 1),
  localparam int TMAX = (RSTH_STD > RSTH_OD) ? RSTH_STD : RSTH_OD,
  localparam int TW = $clog2(TMAX + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busIn,
  input  ctlStrobe_t    ctl,
  output logic          busSync,
  output logic          lowEnd,
  output logic [LW-1:0] lowLen,
  output logic          seqOd,
  output logic          hitPdh,
  output logic          hitPdl,
  output logic          hitRsth
);

  localparam logic [LW-1:0] LONG_L   = LW'(LONG_CLKS);
  localparam logic [TW-1:0] PDH_S_E  = TW'(PDH_STD - 1);
  localparam logic [TW-1:0] PDL_S_E  = TW'(PDH_STD + PDL_STD - 1);
  localparam logic [TW-1:0] RSTH_S_E = TW'(RSTH_STD - 1);
  localparam logic [TW-1:0] PDH_O_E  = TW'(PDH_OD - 1);
  localparam logic [TW-1:0] PDL_O_E  = TW'(PDH_OD + PDL_OD - 1);
  localparam logic [TW-1:0] RSTH_O_E = TW'(RSTH_OD - 1);

  logic          syncA;
  logic [LW-1:0] lowCnt;
  logic [TW-1:0] seqTmr;

  // two-flop synchronizer, idle level is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= 1'b1;
      busSync <= 1'b1;
    end else begin
      syncA   <= busIn;
      busSync <= syncA;
    end
  end

  // saturating low-period counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
    end else if (!ctl.measEn || busSync) begin
      lowCnt <= '0;
    end else if (lowCnt != LONG_L) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  assign lowLen = lowCnt;
  assign lowEnd = busSync && (lowCnt != '0);

  // sequence timer and latched speed
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqTmr <= '0;
      seqOd  <= 1'b0;
    end else if (ctl.startSeq) begin
      seqTmr <= '0;
      seqOd  <= ctl.keepOd;
    end else if (ctl.seqRun) begin
      seqTmr <= seqTmr + 1'b1;
    end
  end

  always_comb begin
    if (seqOd) begin
      hitPdh  = (seqTmr == PDH_O_E);
      hitPdl  = (seqTmr == PDL_O_E);
      hitRsth = (seqTmr == RSTH_O_E);
    end else begin
      hitPdh  = (seqTmr == PDH_S_E);
      hitPdl  = (seqTmr == PDL_S_E);
      hitRsth = (seqTmr == RSTH_S_E);
    end
  end

endmodule

// File: rtl/owrp_control.sv
module owrp_control
  import owrp_pkg::*;
#(
  parameter int LONG_CLKS   = 24000,
  parameter int OD_MIN_CLKS = 2400,
  parameter int OD_MAX_CLKS = 4000,
  parameter int PDH_STD     = 1500,
  parameter int PDL_STD     = 6000,
  parameter int RSTH_STD    = 24000,
  parameter int PDH_OD      = 150,
  parameter int PDL_OD      = 600,
  parameter int RSTH_OD     = 2400,
  parameter int REC_CLKS    = 250,
  localparam int LW = $clog2(LONG_CLKS + 1),
  localparam int TMAX = (RSTH_STD > RSTH_OD) ? RSTH_STD : RSTH_OD,
  localparam int TW = $clog2(TMAX + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          odMode,
  input  logic          busSync,
  input  logic          lowEnd,
  input  logic [LW-1:0] lowLen,
  input  logic          seqOd,
  input  logic          hitPdh,
  input  logic          hitPdl,
  input  logic          hitRsth,
  output ctlStrobe_t    ctl,
  output logic          pullDown,
  output logic          resetPulse,
  output logic          speedDrop,
  output logic          slotEnd,
  output logic          readyPulse
);

  localparam logic [LW-1:0] LONG_L  = LW'(LONG_CLKS);
  localparam logic [LW-1:0] ODMIN_L = LW'(OD_MIN_CLKS);
  localparam logic [LW-1:0] ODMAX_L = LW'(OD_MAX_CLKS);

  seqState_t state;
  logic      armed;
  logic      doClass, isReset, keepOd, lenLong, odHit;

  assign lenLong = (lowLen >= LONG_L);
  assign odHit   = odMode && (lowLen >= ODMIN_L);
  assign isReset = lenLong || odHit;
  assign keepOd  = odHit && (lowLen <= ODMAX_L);
  assign doClass = ctl.measEn && lowEnd;

  assign ctl.startSeq = doClass && isReset;
  assign ctl.keepOd   = keepOd;
  assign ctl.seqRun   = (state != ST_IDLE);
  assign ctl.measEn   = (state == ST_IDLE) && armed;

  assign pullDown = (state == ST_PRES);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      armed      <= 1'b0;
      resetPulse <= 1'b0;
      speedDrop  <= 1'b0;
      slotEnd    <= 1'b0;
      readyPulse <= 1'b0;
    end else begin
      resetPulse <= doClass && isReset;
      speedDrop  <= doClass && isReset && !keepOd;
      slotEnd    <= doClass && !isReset;
      readyPulse <= (state == ST_REC) && hitRsth;
      // measure only lows that begin after the line was seen idle
      if (ctl.startSeq) armed <= 1'b0;
      else if (state == ST_IDLE && busSync) armed <= 1'b1;
      case (state)
        ST_IDLE: if (ctl.startSeq) state <= ST_WAIT;
        ST_WAIT: if (hitPdh) state <= ST_PRES;
        ST_PRES: if (hitPdl) state <= ST_REC;
        ST_REC:  if (hitRsth) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // ---------------- checks ----------------
  localparam logic [TW-1:0] PDL_S_L = TW'(PDL_STD - 1);
  localparam logic [TW-1:0] PDL_O_L = TW'(PDL_OD - 1);

  logic [TW-1:0] pdRun;
  logic          pdSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pdRun  <= '0;
      pdSeen <= 1'b0;
    end else begin
      pdRun <= pullDown ? pdRun + 1'b1 : '0;
      if (pullDown) pdSeen <= 1'b1;
      else if (readyPulse) pdSeen <= 1'b0;
    end
  end

  initial begin
    // R7: recovery window covers presence plus recovery time
    a_r7_window_fits: assert (RSTH_STD >= PDH_STD + PDL_STD + REC_CLKS &&
                              RSTH_OD >= PDH_OD + PDL_OD + REC_CLKS);
  end

  a_r1_long_drops_speed: assert property (@(posedge clk) disable iff (!rstN)
    (resetPulse && ($past(lowLen) >= LONG_L)) |-> speedDrop);

  a_r6_presence_width: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pullDown) |-> ($past(pdRun) == (seqOd ? PDL_O_L : PDL_S_L)));

  a_r7_ready_after_presence: assert property (@(posedge clk) disable iff (!rstN)
    readyPulse |-> (pdSeen && !pullDown));

  a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({resetPulse, slotEnd, readyPulse}));

  a_r10_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    resetPulse |=> !resetPulse);

endmodule

// File: rtl/owire_reset_responder.sv
module owire_reset_responder
  import owrp_pkg::*;
#(
  parameter int LONG_CLKS   = 24000,
  parameter int OD_MIN_CLKS = 2400,
  parameter int OD_MAX_CLKS = 4000,
  parameter int PDH_STD     = 1500,
  parameter int PDL_STD     = 6000,
  parameter int RSTH_STD    = 24000,
  parameter int PDH_OD      = 150,
  parameter int PDL_OD      = 600,
  parameter int RSTH_OD     = 2400,
  parameter int REC_CLKS    = 250,
  localparam int LW = $clog2(LONG_CLKS + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic busIn,
  input  logic odMode,
  output logic pullDown,
  output logic resetPulse,
  output logic speedDrop,
  output logic slotEnd,
  output logic readyPulse
);

  ctlStrobe_t    ctl;
  logic          busSync, lowEnd, seqOd, hitPdh, hitPdl, hitRsth;
  logic [LW-1:0] lowLen;

  owrp_datapath #(
    .LONG_CLKS(LONG_CLKS), .PDH_STD(PDH_STD), .PDL_STD(PDL_STD),
    .RSTH_STD(RSTH_STD), .PDH_OD(PDH_OD), .PDL_OD(PDL_OD), .RSTH_OD(RSTH_OD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .busIn(busIn), .ctl(ctl),
    .busSync(busSync), .lowEnd(lowEnd), .lowLen(lowLen), .seqOd(seqOd),
    .hitPdh(hitPdh), .hitPdl(hitPdl), .hitRsth(hitRsth)
  );

  owrp_control #(
    .LONG_CLKS(LONG_CLKS), .OD_MIN_CLKS(OD_MIN_CLKS), .OD_MAX_CLKS(OD_MAX_CLKS),
    .PDH_STD(PDH_STD), .PDL_STD(PDL_STD), .RSTH_STD(RSTH_STD),
    .PDH_OD(PDH_OD), .PDL_OD(PDL_OD), .RSTH_OD(RSTH_OD), .REC_CLKS(REC_CLKS)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .odMode(odMode), .busSync(busSync),
    .lowEnd(lowEnd), .lowLen(lowLen), .seqOd(seqOd),
    .hitPdh(hitPdh), .hitPdl(hitPdl), .hitRsth(hitRsth), .ctl(ctl),
    .pullDown(pullDown), .resetPulse(resetPulse), .speedDrop(speedDrop),
    .slotEnd(slotEnd), .readyPulse(readyPulse)
  );

endmodule

// File: tb/test_owire_reset_responder.sv
`timescale 1ns/1ps
module test_owire_reset_responder;

  localparam int LONG  = 480;
  localparam int ODMIN = 48;
  localparam int ODMAX = 80;
  localparam int PDHS = 30, PDLS = 120, RSTHS = 480;
  localparam int PDHO = 3,  PDLO = 12,  RSTHO = 48;
  localparam int REC  = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterLow = 1'b0;
  logic odMode = 1'b0;
  logic busIn;
  logic pullDown, resetPulse, speedDrop, slotEnd, readyPulse;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  assign busIn = !(masterLow || pullDown);

  owire_reset_responder #(
    .LONG_CLKS(LONG), .OD_MIN_CLKS(ODMIN), .OD_MAX_CLKS(ODMAX),
    .PDH_STD(PDHS), .PDL_STD(PDLS), .RSTH_STD(RSTHS),
    .PDH_OD(PDHO), .PDL_OD(PDLO), .RSTH_OD(RSTHO), .REC_CLKS(REC)
  ) i_owire_reset_responder (
    .clk(clk), .rstN(rstN), .busIn(busIn), .odMode(odMode),
    .pullDown(pullDown), .resetPulse(resetPulse), .speedDrop(speedDrop),
    .slotEnd(slotEnd), .readyPulse(readyPulse)
  );

  // 0 = slot, 1 = reset keeping overdrive, 2 = reset to standard speed
  function automatic int classify(int len, bit od);
    if (len >= LONG) return 2;
    if (od && len >= ODMIN && len <= ODMAX) return 1;
    if (od && len > ODMAX) return 2;
    return 0;
  endfunction

  function automatic string reqTag(int len, bit od);
    int c = classify(len, od);
    if (c == 0) return od ? "R5" : "R2";
    if (len >= LONG) return "R1";
    return (c == 1) ? "R3" : "R4";
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic runLow(int len, bit od);
    int cls = classify(len, od);
    string tag = reqTag(len, od);
    int early = 0;
    @(negedge clk);
    odMode = od;
    masterLow = 1'b1;
    repeat (len) @(negedge clk);
    masterLow = 1'b0;
    repeat (2) begin
      @(negedge clk);
      early += int'(resetPulse) + int'(slotEnd);
    end
    @(negedge clk);
    check("R10", "no strobe before third edge", early, 0);
    check(tag, "resetPulse", int'(resetPulse), int'(cls != 0));
    check(tag, "slotEnd", int'(slotEnd), int'(cls == 0));
    if (cls != 0) begin
      int pdh = (cls == 1) ? PDHO : PDHS;
      int pdl = (cls == 1) ? PDLO : PDLS;
      int rsth = (cls == 1) ? RSTHO : RSTHS;
      int first = -1, width = 0, readyAt = -1, readyCnt = 0;
      check(tag, "speedDrop", int'(speedDrop), int'(cls == 2));
      for (int k = 1; k <= rsth + 2; k++) begin
        @(negedge clk);
        if (pullDown) begin
          if (first < 0) first = k;
          width++;
        end
        if (readyPulse) begin
          readyCnt++;
          if (readyAt < 0) readyAt = k;
        end
      end
      check("R6", "presence start", first, pdh);
      check("R6", "presence width", width, pdl);
      check("R7", "ready time", readyAt, rsth);
      check("R10", "ready single cycle", readyCnt, 1);
    end else begin
      int pd = 0;
      repeat (40) begin
        @(negedge clk);
        pd += int'(pullDown) + int'(resetPulse);
      end
      check(tag, "no presence after slot", pd, 0);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    begin
      int any = 0;
      repeat (20) begin
        @(negedge clk);
        any += int'(pullDown) + int'(resetPulse) + int'(speedDrop) +
               int'(slotEnd) + int'(readyPulse);
      end
      check("R9", "outputs idle after reset", any, 0);
    end

    // directed thresholds
    runLow(1, 1'b0);
    runLow(LONG - 1, 1'b0);
    runLow(LONG, 1'b0);
    runLow(ODMIN - 1, 1'b1);
    runLow(ODMIN, 1'b1);
    runLow(ODMAX, 1'b1);
    runLow(ODMAX + 1, 1'b1);
    runLow(LONG - 1, 1'b1);
    runLow(LONG, 1'b1);
    runLow(LONG + 100, 1'b0);

    // R8: master low begins inside the presence pulse
    begin
      int stray = 0;
      @(negedge clk);
      odMode = 1'b0;
      masterLow = 1'b1;
      repeat (LONG) @(negedge clk);
      masterLow = 1'b0;
      repeat (3) @(negedge clk);
      check("R8", "reset before overlap", int'(resetPulse), 1);
      repeat (PDHS + 5) @(negedge clk);
      masterLow = 1'b1;
      repeat (LONG + 120) @(negedge clk);
      masterLow = 1'b0;
      repeat (12) begin
        @(negedge clk);
        stray += int'(resetPulse) + int'(slotEnd);
      end
      check("R8", "overlapping low not classified", stray, 0);
      check("R9", "pulldown released", int'(pullDown), 0);
    end
    runLow(LONG, 1'b0);

    // constrained random lengths and speeds
    for (int i = 0; i < 24; i++) begin
      int len = 1 + int'($urandom_range(LONG + 60, 0));
      bit od = 1'($urandom_range(1, 0));
      if (i % 3 == 0) len = ODMIN - 4 + int'($urandom_range(ODMAX - ODMIN + 8, 0));
      runLow(len, od);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule